// File: doc/BRIEF.md
# Reference-Gated Clock Frequency Counter

This debug block measures how fast an unknown test clock runs by counting its edges during a window timed by a known reference clock. Software writes a window length, in reference ticks, together with a start bit into a control word. A timer in the reference domain counts the window down. While the window is open, a counter clocked by the test clock counts its rising edges. When the window closes, the final count is handed back to the reference domain and a done flag rises. The count is then read from a status word. The test frequency is the count times the reference frequency divided by the window length.

The test-clock counter is cleared only by an edge of the test clock, at the start of a window. A stopped test clock therefore leaves the count of the last real measurement in place. To find out whether the clock runs, software takes two windows of different lengths and compares the results: equal counts mean the clock is stopped. A bounded wait for the return handshake makes sure done still rises in that case.

The register port is a plain synchronous write strobe, a one-bit select and a combinational read bus, all on the reference clock.

Top module: `freq_meter`

## Requirements
- R1: After an active-low reset the control word reads 0 and the status word reads 0, so the done flag and the captured count are both clear.
- R2: The control word (select 0) holds the window length in bits WIN_W-1:0 (default 20 bits) and the start bit at bit WIN_W (bit 20). It reads back exactly those bits, and every higher bit reads 0.
- R3: The status word (select 1) carries the captured count in bits CNT_W-1:0 and the done flag at bit CNT_W (bit 25 with the defaults). Every higher bit reads 0.
- R4: Writing the control word with the start bit clear stops the window, clears done so that it reads 0 from the next cycle, and keeps done at 0 until a new measurement is started.
- R5: A write with the start bit set and a window of W ticks yields a count within ±2 of W·f_test/f_ref for test clocks slower than, as fast as, and faster than the reference.
- R6: Done stays 0 for at least W reference cycles after the start write. It rises only after the window has closed and the count has come back through the request/acknowledge handshake, or after that handshake has timed out.
- R7: When the test clock is stopped, done still rises within W + ACK_TMO + 4 reference cycles, and the count is left equal to the result of the previous measurement.
- R8: A count that would exceed CNT_W bits saturates at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; times the window and runs the register port |
| ref_rst_n | input | 1 | Active-low reset, asynchronous in the reference domain |
| tst_clk | input | 1 | Clock under measurement |
| reg_wr | input | 1 | Write strobe; writes the control word when reg_sel is 0 |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |

## Verification
The test clock is run at half the reference rate, at the same rate, and at 4/3, 5/3 and twice the reference rate, with several window lengths. This separates scaling errors from off-by-one window lengths, since an error in the window length grows with the ratio while an error in the synchronizers does not. A window long enough to overflow the counter shows whether the count saturates or wraps. Stopping the test clock shows that the earlier count is kept and that done does not hang. Aborting a window midway and probing done one cycle before the window ends show that the handshake cannot finish early.

// File: rtl/fm_pkg.sv
package fm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RUN  = 3'd1,
        ST_WAIT = 3'd2,
        ST_REQ  = 3'd3,
        ST_DONE = 3'd4
    } fm_state_e;

    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_STAT = 1'b1;

endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/fm_tst_cnt.sv
module fm_tst_cnt #(
    parameter int CNT_W = 25
) (
    input  logic             tst_clk,
    input  logic             tst_rst_n,
    input  logic             gate_i,
    input  logic             req_i,
    output logic             ack_o,
    output logic [CNT_W-1:0] hold_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             gate_p;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hold;
        logic             ack;
    } tst_s;

    tst_s r_d, r_q;
    logic gate_s, req_s;

    fm_sync #(.W(2)) u_sync (
        .clk   (tst_clk),
        .rst_n (1'b1),
        .d_i   ({gate_i, req_i}),
        .q_o   ({gate_s, req_s})
    );

    always_comb begin
        r_d        = r_q;
        r_d.gate_p = gate_s;
        if (gate_s && !r_q.gate_p) begin
            r_d.cnt = {{(CNT_W-1){1'b0}}, 1'b1};
        end else if (gate_s && r_q.cnt != CNT_MAX) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
        if (req_s && !r_q.ack) begin
            r_d.hold = r_q.cnt;
            r_d.ack  = 1'b1;
        end else if (!req_s) begin
            r_d.ack = 1'b0;
        end
    end

    // Reset is synchronous to the test clock: with no test edges, nothing clears.
    always_ff @(posedge tst_clk) begin
        if (!tst_rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ack_o  = r_q.ack;
    assign hold_o = r_q.hold;

    // R8
    sat_hold_chk: assert property (@(posedge tst_clk) disable iff (!tst_rst_n)
        (r_q.cnt == CNT_MAX && gate_s && r_q.gate_p) |=> (r_q.cnt == CNT_MAX));

    // R6
    ack_on_req_chk: assert property (@(posedge tst_clk) disable iff (!tst_rst_n)
        $rose(r_q.ack) |-> $past(req_s));

    // R5
    hold_steady_chk: assert property (@(posedge tst_clk) disable iff (!tst_rst_n)
        (r_q.ack && $past(r_q.ack)) |-> $stable(r_q.hold));
endmodule

// File: rtl/fm_ref_ctrl.sv
module fm_ref_ctrl
    import fm_pkg::*;
#(
    parameter int WIN_W   = 20,
    parameter int CNT_W   = 25,
    parameter int ACK_TMO = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             sel_i,
    input  logic [31:0]      wdata_i,
    output logic [31:0]      rdata_o,
    output logic             gate_o,
    output logic             req_o,
    input  logic             ack_i,
    input  logic [CNT_W-1:0] hold_i
);
    localparam int TMO_W = $clog2(ACK_TMO + 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(ACK_TMO - 1);

    typedef struct packed {
        fm_state_e        st;
        logic [WIN_W:0]   ctrl;
        logic [WIN_W-1:0] tmr;
        logic [TMO_W-1:0] tmo;
        logic             gate;
        logic             req;
        logic             done;
        logic [CNT_W-1:0] cap;
    } ctl_s;

    ctl_s r_d, r_q;
    logic ack_s;
    logic ctl_wr;

    fm_sync #(.W(1)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ack_i),
        .q_o   (ack_s)
    );

    assign ctl_wr = wr_i && (sel_i == SEL_CTRL);

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_RUN: begin
                if (r_q.tmr <= WIN_W'(1)) begin
                    r_d.st   = ST_WAIT;
                    r_d.gate = 1'b0;
                    r_d.tmo  = '0;
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            ST_WAIT, ST_REQ: begin
                if (r_q.st == ST_REQ && ack_s) begin
                    r_d.cap  = hold_i;
                    r_d.done = 1'b1;
                    r_d.req  = 1'b0;
                    r_d.st   = ST_DONE;
                end else if (r_q.tmo == TMO_LAST) begin
                    r_d.done = 1'b1;
                    r_d.req  = 1'b0;
                    r_d.st   = ST_DONE;
                end else begin
                    r_d.tmo = r_q.tmo + 1'b1;
                    if (r_q.st == ST_WAIT && !ack_s) begin
                        r_d.st  = ST_REQ;
                        r_d.req = 1'b1;
                    end
                end
            end
            default: ;
        endcase
        if (ctl_wr) begin
            r_d.ctrl = wdata_i[WIN_W:0];
            r_d.done = 1'b0;
            r_d.req  = 1'b0;
            r_d.tmo  = '0;
            if (wdata_i[WIN_W]) begin
                r_d.st   = ST_RUN;
                r_d.gate = 1'b1;
                r_d.tmr  = wdata_i[WIN_W-1:0];
            end else begin
                r_d.st   = ST_IDLE;
                r_d.gate = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (sel_i == SEL_STAT) begin
            rdata_o[CNT_W-1:0] = r_q.cap;
            rdata_o[CNT_W]     = r_q.done;
        end else begin
            rdata_o[WIN_W:0] = r_q.ctrl;
        end
    end

    assign gate_o = r_q.gate;
    assign req_o  = r_q.req;

    // R4
    stop_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wdata_i[WIN_W]) |=> (!r_q.gate && !r_q.done));

    // R6
    done_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.done) |-> ($past(r_q.st) == ST_REQ || $past(r_q.st) == ST_WAIT));

    // R7
    timeout_keeps_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(r_q.done) && !$past(r_q.req && ack_s)) |-> $stable(r_q.cap));

    // R6
    gate_closed_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> (!r_q.gate && !r_q.req));
endmodule

// File: rtl/freq_meter.sv
module freq_meter #(
    parameter int WIN_W   = 20,
    parameter int CNT_W   = 25,
    parameter int ACK_TMO = 64
) (
    input  logic        ref_clk,
    input  logic        ref_rst_n,
    input  logic        tst_clk,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    logic             gate, req, ack, tst_rst_n;
    logic [CNT_W-1:0] hold;

    fm_sync #(.W(1)) u_tst_rst (
        .clk   (tst_clk),
        .rst_n (1'b1),
        .d_i   (ref_rst_n),
        .q_o   (tst_rst_n)
    );

    fm_ref_ctrl #(.WIN_W(WIN_W), .CNT_W(CNT_W), .ACK_TMO(ACK_TMO)) u_ctrl (
        .clk     (ref_clk),
        .rst_n   (ref_rst_n),
        .wr_i    (reg_wr),
        .sel_i   (reg_sel),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .gate_o  (gate),
        .req_o   (req),
        .ack_i   (ack),
        .hold_i  (hold)
    );

    fm_tst_cnt #(.CNT_W(CNT_W)) u_tst (
        .tst_clk   (tst_clk),
        .tst_rst_n (tst_rst_n),
        .gate_i    (gate),
        .req_i     (req),
        .ack_o     (ack),
        .hold_o    (hold)
    );
endmodule

// File: tb/tb_freq_meter.sv
`timescale 1ps/1ps
module tb_freq_meter;
    localparam int WIN_W   = 20;
    localparam int CNT_W   = 12;
    localparam int ACK_TMO = 64;
    localparam int REF_PS  = 5000;
    localparam int EN      = 1 << WIN_W;
    localparam int CMASK   = (1 << CNT_W) - 1;
    localparam int NVEC    = 6;
    // {window ticks, test clock period ps}
    localparam int VEC [NVEC][2] = '{
        '{400, 10000}, '{400, 5000}, '{400, 2500},
        '{300, 3750},  '{999, 7500}, '{1500, 3000}
    };

    logic        ref_clk = 0, tst_clk = 0, ref_rst_n = 0;
    logic        reg_wr = 0, reg_sel = 1;
    logic [31:0] reg_wdata = 0, reg_rdata;
    int          tst_half = 2500;
    bit          tst_run = 1;
    int          n_run = 0, n_fail = 0;

    freq_meter #(.WIN_W(WIN_W), .CNT_W(CNT_W), .ACK_TMO(ACK_TMO)) dut (
        .ref_clk   (ref_clk),
        .ref_rst_n (ref_rst_n),
        .tst_clk   (tst_clk),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    always #(REF_PS/2) ref_clk = ~ref_clk;
    initial forever begin
        if (tst_run) begin
            #(tst_half) tst_clk = ~tst_clk;
        end else begin
            #1000;
        end
    end

    task automatic check(string tag, int act, int exp, int tol);
        n_run++;
        if (act > exp + tol || act < exp - tol) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (tol %0d)", tag, act, exp, tol);
        end
    endtask

    task automatic wr_ctrl(int val);
        @(negedge ref_clk);
        reg_wr = 1; reg_sel = 0; reg_wdata = val;
        @(negedge ref_clk);
        reg_wr = 0; reg_sel = 1;
    endtask

    task automatic rd(bit sel, output int val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
        reg_sel = 1;
    endtask

    // Starts a window, waits for done, returns count and cycles waited.
    task automatic measure(int win, output int cnt, output int waited);
        int s;
        wr_ctrl(0);
        wr_ctrl(EN | win);
        waited = 0;
        s = 0;
        while (waited < win + ACK_TMO + 200) begin
            rd(1, s);
            if (s[CNT_W]) break;
            @(negedge ref_clk);
            waited++;
        end
        cnt = s & CMASK;
        check("R6 done reached", s[CNT_W], 1, 0);
    endtask

    initial begin
        #(REF_PS * 190000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int v, c, w, prev;
        repeat (5) @(negedge ref_clk);
        rd(0, v); check("R1 ctrl after reset", v, 0, 0);
        rd(1, v); check("R1 status after reset", v, 0, 0);
        ref_rst_n = 1;
        repeat (5) @(negedge ref_clk);
        rd(1, v); check("R1 status after release", v, 0, 0);

        // R5: table of ratios and windows
        for (int i = 0; i < NVEC; i++) begin
            tst_half = VEC[i][1] / 2;
            repeat (10) @(negedge ref_clk);
            measure(VEC[i][0], c, w);
            check($sformatf("R5 vec%0d count", i), c,
                  (VEC[i][0] * REF_PS + VEC[i][1] / 2) / VEC[i][1], 2);
        end

        // R2: control layout and readback
        wr_ctrl(32'hFFEF_FFFF);
        rd(0, v); check("R2 ctrl masked readback", v, 32'h000F_FFFF, 0);
        wr_ctrl(EN | 5);
        rd(0, v); check("R2 ctrl enable readback", v, EN | 5, 0);
        repeat (100) @(negedge ref_clk);

        // R3: status layout, upper bits zero, done bit position
        tst_half = 2500;
        measure(100, c, w);
        rd(1, v);
        check("R3 status upper bits", v >> (CNT_W + 1), 0, 0);
        check("R3 done bit", (v >> CNT_W) & 1, 1, 0);
        check("R3 count field", v & CMASK, 100, 2);

        // R4: clear drops done; abort midway keeps done low
        wr_ctrl(200);
        rd(1, v); check("R4 done cleared", (v >> CNT_W) & 1, 0, 0);
        wr_ctrl(EN | 300);
        repeat (50) @(negedge ref_clk);
        wr_ctrl(300);
        repeat (500) @(negedge ref_clk);
        rd(1, v); check("R4 aborted stays not done", (v >> CNT_W) & 1, 0, 0);
        rd(0, v); check("R4 enable reads clear", (v >> WIN_W) & 1, 0, 0);

        // R6: done not before the window has elapsed
        wr_ctrl(EN | 200);
        repeat (199) @(negedge ref_clk);
        rd(1, v); check("R6 no early done", (v >> CNT_W) & 1, 0, 0);
        repeat (200) @(negedge ref_clk);
        rd(1, v); check("R6 done later", (v >> CNT_W) & 1, 1, 0);

        // R8: saturation
        tst_half = 1250;
        repeat (10) @(negedge ref_clk);
        measure(3000, c, w);
        check("R8 saturated count", c, CMASK, 0);

        // R7: stopped clock keeps the previous count
        tst_half = 2500;
        repeat (10) @(negedge ref_clk);
        measure(300, prev, w);
        check("R7 baseline", prev, 300, 2);
        tst_run = 0;
        repeat (20) @(negedge ref_clk);
        measure(100, c, w);
        check("R7 count unchanged", c, prev, 0);
        check("R7 done bounded", (w <= 100 + ACK_TMO + 6) ? 1 : 0, 1, 0);
        tst_run = 1;
        repeat (20) @(negedge ref_clk);
        measure(150, c, w);
        check("R7 recovery count", c, 150, 2);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule